// File: doc/BRIEF.md
# Prioritised Interrupt Acknowledge Interface

This block sits between a set of interrupt sources and one processing element. Every cycle it looks at each source's pending flag, enable bit, 8-bit priority, group bit and security bit. It picks the most urgent source that beats the processing element's priority mask and registers that choice. It raises exactly one of two request lines, fast or normal. The line is chosen from the source's group and security bits and the processing element's current security state and exception level.

Software takes an interrupt by issuing an acknowledge read. In that same cycle the block returns the registered ID and emits an acknowledge strobe, which tells the per-source tracker to retire the pending flag. The block then drops its request for one settle cycle. This keeps the stale selection from being offered twice. When nothing qualifies, the read returns the reserved ID 1023 and no strobe is produced.

A three-state machine controls the request. The states are IDLE (no request), REQ (request driven, selection valid) and SETTLE (one cycle after an acknowledge). The transitions are:
- IDLE to REQ when a candidate qualifies.
- REQ to IDLE when the candidate disappears without a read.
- REQ to SETTLE on an acknowledge read.
- SETTLE to REQ when a candidate is present.
- SETTLE to IDLE when no candidate is present.

Top module: `irq_ack_if`

## Requirements
- R1: A request line (fast_req or norm_req) is driven only when at least one source is pending, enabled and has a priority value strictly less than prio_mask. The lines follow the inputs one clock edge later.
- R2: The selected source is the one with the smallest priority value. When priority values are equal, the lowest source index wins, and the returned ID equals that index.
- R3: An acknowledge read in the REQ state returns the selected ID on ack_id and pulses ack_strobe in the same cycle. Both request lines are low in the following cycle.
- R4: When no source qualifies, or during the settle cycle, ack_id reads 1023 and an acknowledge read produces no ack_strobe.
- R5: A selected source with group bit 0 is signalled on fast_req.
- R6: pe_state is coded as follows: 0 is secure low level, 1 is non-secure low level, 2 and 3 are the highest level. At a low level, a group 1 source whose security bit (1 = secure) matches the processing element's state is signalled on norm_req. A group 1 source whose security bit does not match is signalled on fast_req.
- R7: With pe_state 2 or 3, every selected source is signalled on fast_req.
- R8: After reset both request lines are low, ack_strobe is low and ack_id reads 1023.
- R9: ack_id comes from a register, so input changes made in the cycle of an acknowledge read do not alter the ID returned by that read.
- R10: After the settle cycle, a remaining qualifying source is requested again one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend | input | NUM_SRC | Pending flag per source |
| src_en | input | NUM_SRC | Enable per source |
| src_prio | input | NUM_SRC*PRIO_W | Priority value per source, source i at bits i*PRIO_W upward |
| src_grp | input | NUM_SRC | Group bit per source |
| src_sec | input | NUM_SRC | Security bit per source, 1 = secure |
| prio_mask | input | PRIO_W | Priority threshold |
| pe_state | input | 2 | Processing element security state and exception level |
| ack_rd | input | 1 | Acknowledge read |
| ack_id | output | ID_W | ID returned to an acknowledge read |
| ack_strobe | output | 1 | Acknowledge pulse to the source tracker |
| fast_req | output | 1 | Fast interrupt request |
| norm_req | output | 1 | Normal interrupt request |

## Verification
The request lines and ack_id are registered, so they reflect a new input pattern one edge after it is applied. The bench drives on the falling edge and samples on the next falling edge. ack_strobe is combinational from ack_rd, so it is checked in the cycle of the read. The request drop is checked one edge after the read. The re-request of a remaining source is checked one edge after that. The bench models the source tracker by clearing the acknowledged pending bit before the settle edge. This makes the expected winner after the settle cycle the bench's own recomputation.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ    = 2'd1,
        ST_SETTLE = 2'd2
    } ack_state_t;

    localparam logic [1:0] PE_SEC_LOW = 2'd0;
    localparam logic [1:0] PE_NS_LOW  = 2'd1;
endpackage

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 8,
    parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC-1:0]        en,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         mask,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx
);
    logic [NUM_SRC-1:0] qual;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_qual
            assign qual[g] = pend[g] & en[g] & (prio[g*PRIO_W +: PRIO_W] < mask);
        end
    endgenerate

    logic [PRIO_W-1:0] best;
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        best    = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (qual[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                best    = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_line_class.sv
module irq_line_class
    import irq_ack_pkg::*;
(
    input  logic       grp,
    input  logic       sec,
    input  logic [1:0] pe_state,
    output logic       use_fast
);
    logic pe_low;
    logic pe_secure;

    always_comb begin
        pe_low    = (pe_state == PE_SEC_LOW) || (pe_state == PE_NS_LOW);
        pe_secure = (pe_state == PE_SEC_LOW);
        use_fast  = !grp || !pe_low || (sec != pe_secure);
    end
endmodule

// File: rtl/irq_ack_if.sv
module irq_ack_if
    import irq_ack_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 8,
    parameter int ID_W    = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_pend,
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [NUM_SRC-1:0]        src_grp,
    input  logic [NUM_SRC-1:0]        src_sec,
    input  logic [PRIO_W-1:0]         prio_mask,
    input  logic [1:0]                pe_state,
    input  logic                      ack_rd,
    output logic [ID_W-1:0]           ack_id,
    output logic                      ack_strobe,
    output logic                      fast_req,
    output logic                      norm_req
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

    logic             cand_found;
    logic [IDX_W-1:0] cand_idx;
    logic             cand_fast;

    irq_prio_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
        .pend    (src_pend),
        .en      (src_en),
        .prio    (src_prio),
        .mask    (prio_mask),
        .found   (cand_found),
        .win_idx (cand_idx)
    );

    irq_line_class u_cls (
        .grp      (src_grp[cand_idx]),
        .sec      (src_sec[cand_idx]),
        .pe_state (pe_state),
        .use_fast (cand_fast)
    );

    ack_state_t       state_q, state_d;
    logic [IDX_W-1:0] sel_idx_q;
    logic             sel_fast_q;
    logic             sel_valid_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cand_found) state_d = ST_REQ;
            ST_REQ: begin
                if (ack_rd)           state_d = ST_SETTLE;
                else if (!cand_found) state_d = ST_IDLE;
            end
            ST_SETTLE: state_d = cand_found ? ST_REQ : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            sel_idx_q   <= '0;
            sel_fast_q  <= 1'b0;
            sel_valid_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            sel_idx_q   <= cand_idx;
            sel_fast_q  <= cand_fast;
            sel_valid_q <= cand_found;
        end
    end

    always_comb begin
        fast_req   = 1'b0;
        norm_req   = 1'b0;
        ack_id     = NONE_ID;
        ack_strobe = 1'b0;
        unique case (state_q)
            ST_REQ: begin
                fast_req   = sel_fast_q;
                norm_req   = !sel_fast_q;
                ack_id     = ID_W'(sel_idx_q);
                ack_strobe = ack_rd;
            end
            default: ;
        endcase
    end

    AST_REQ_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_req || norm_req) |-> (sel_valid_q && ack_id != NONE_ID)); // R1
    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ack_strobe |=> (!fast_req && !norm_req)); // R3
    AST_NONE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && ack_id == NONE_ID) |-> !ack_strobe); // R4
    AST_TOP_LEVEL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_q && $past(pe_state[1])) |-> !norm_req); // R7
    AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fast_req, norm_req, state_q == ST_SETTLE})); // R3
endmodule

// File: tb/irq_ack_if_tb.sv
module irq_ack_if_tb;
    localparam int N = 8;
    localparam int PW = 8;
    localparam int IW = 10;
    localparam int NONE = 1023;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pend = '0, en = '0, grp = '0, sec = '0;
    logic [N*PW-1:0] prio = '0;
    logic [PW-1:0] mask = '0;
    logic [1:0] pe = '0;
    logic ack_rd = 1'b0;
    logic [IW-1:0] ack_id;
    logic ack_strobe, fast_req, norm_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    irq_ack_if #(.NUM_SRC(N), .PRIO_W(PW), .ID_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_pend(pend), .src_en(en), .src_prio(prio),
        .src_grp(grp), .src_sec(sec), .prio_mask(mask), .pe_state(pe),
        .ack_rd(ack_rd), .ack_id(ack_id), .ack_strobe(ack_strobe),
        .fast_req(fast_req), .norm_req(norm_req)
    );

    function automatic int exp_winner();
        int w = -1;
        int bp = 0;
        for (int i = 0; i < N; i++) begin
            int p = int'(prio[i*PW +: PW]);
            if (pend[i] && en[i] && p < int'(mask) && (w < 0 || p < bp)) begin
                w = i;
                bp = p;
            end
        end
        return w;
    endfunction

    function automatic bit exp_fast(int w);
        if (!grp[w]) return 1'b1;
        if (pe >= 2) return 1'b1;
        return sec[w] != (pe == 0);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_sel(string req);
        int w = exp_winner();
        if (w < 0) begin
            chk(req, ack_id, NONE);
            chk(req, {fast_req, norm_req}, 0);
        end else begin
            chk(req, ack_id, w);
            chk(req, fast_req, exp_fast(w));
            chk(req, norm_req, !exp_fast(w));
        end
    endtask

    function automatic logic [31:0] nxt(logic [31:0] v);
        logic [31:0] x = v;
        x ^= x << 13;
        x ^= x >> 17;
        x ^= x << 5;
        return x;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", {fast_req, norm_req, ack_strobe}, 0);
        chk("R8", ack_id, NONE);
        rst_n = 1'b1;
        step();
        chk("R8", ack_id, NONE);

        // R1 mask boundary: single source 2, sweep priority against mask
        pend = 8'h04; en = 8'h04; grp = 8'h04; sec = 8'h00; pe = 2'd1;
        for (int m = 0; m < 256; m += 5) begin
            for (int p = m - 2; p <= m + 1; p++) begin
                if (p >= 0 && p < 256) begin
                    mask = PW'(m);
                    prio[2*PW +: PW] = PW'(p);
                    step();
                    check_sel("R1");
                end
            end
        end
        // R1: disabled source does not request
        mask = 8'hFF; prio[2*PW +: PW] = 8'd3; en = 8'h00;
        step();
        chk("R1", {fast_req, norm_req}, 0);
        chk("R1", ack_id, NONE);
        en = 8'hFF;

        // R5 R6 R7: classification, exhaustive over group, security, pe_state
        for (int g = 0; g < 2; g++)
            for (int s = 0; s < 2; s++)
                for (int q = 0; q < 4; q++) begin
                    grp[2] = g[0]; sec[2] = s[0]; pe = q[1:0];
                    step();
                    if (g == 0) chk("R5", fast_req, 1);
                    else if (q >= 2) chk("R7", fast_req, 1);
                    else chk("R6", norm_req, (s == 1) == (q == 0));
                    check_sel("R6");
                end

        // R2: pseudo-random patterns, winner and tie break
        for (int k = 0; k < 600; k++) begin
            rng = nxt(rng); pend = rng[7:0]; en = rng[15:8]; grp = rng[23:16]; sec = rng[31:24];
            rng = nxt(rng); pe = rng[1:0]; mask = (k % 3 == 0) ? 8'hFF : rng[15:8];
            for (int i = 0; i < N; i++) begin
                rng = nxt(rng);
                prio[i*PW +: PW] = (k % 2 == 0) ? PW'(rng[1:0]) : rng[7:0];
            end
            step();
            check_sel("R2");
        end

        // R3 R4 R9 R10: acknowledge sequence with a tracker model
        pe = 2'd1; grp = 8'hFF; sec = 8'h00; en = 8'hFF; mask = 8'h80;
        for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'(8'h40 - i);
        pend = 8'h0C;                    // sources 2 and 3, 3 wins
        step();
        chk("R2", ack_id, 3);
        ack_rd = 1'b1;
        pend[7] = 1'b1;                  // more urgent source appears with the read
        #1;
        chk("R9", ack_id, 3);
        chk("R3", ack_strobe, 1);
        @(posedge clk);
        @(negedge clk);
        ack_rd = 1'b1;
        pend[3] = 1'b0;                  // tracker retires source 3
        #1;
        chk("R3", {fast_req, norm_req}, 0);
        chk("R4", ack_id, NONE);
        chk("R4", ack_strobe, 0);
        @(posedge clk);
        @(negedge clk);
        ack_rd = 1'b0;
        chk("R10", ack_id, 7);
        chk("R10", norm_req, 1);
        // acknowledge with nothing qualifying
        pend = 8'h00;
        step();
        ack_rd = 1'b1;
        #1;
        chk("R4", ack_id, NONE);
        chk("R4", ack_strobe, 0);
        step();
        ack_rd = 1'b0;
        chk("R4", {fast_req, norm_req}, 0);

        // repeated acknowledge drain of all sources in priority order
        pend = 8'hFF;
        step();
        for (int i = N - 1; i >= 0; i--) begin
            chk("R10", ack_id, i);
            ack_rd = 1'b1;
            #1;
            chk("R3", ack_strobe, 1);
            @(posedge clk);
            @(negedge clk);
            ack_rd = 1'b0;
            pend[i] = 1'b0;
            chk("R3", {fast_req, norm_req}, 0);
            step();
        end
        chk("R4", ack_id, NONE);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule